// File: doc/BRIEF.md
# Phase-Bit Reply Ring Consumer

This block drains completion entries from a circular reply ring held in local slot storage. Each slot is 64 bits wide and its bit 0 is a phase marker. The consumer looks at the slot under its read index and compares that bit with an expected-phase register. A match means a fresh completion, which is offered on a valid/ready stream. No producer index is ever read, and consumed slots are never cleared. The expected phase inverts each time the read index wraps at the programmed ring depth, so an entry left over from the previous pass reads as stale.

A producer port stands in for the controller that fills the ring. It stamps each written slot with its own phase, and that phase toggles when its write index wraps. A credit counter tracks outstanding commands. A submit strobe raises it, each consumed completion lowers it, and it reports a full condition against a programmed limit. The ring depth and the limit are held steady between resets.

Top module: `reply_ring_drain`

## Requirements
- R1: After reset the read and write indices are 0, both phases are 1, and every slot holds 0. The stream shows no valid entry and the outstanding count is 0.
- R2: `cpl_valid` is high exactly when bit 0 of the slot under the read index equals the expected phase. While it is high, `cpl_tag` carries the full 64-bit slot value.
- R3: While `cpl_valid` is low, `cpl_tag` reads 64'h0000_0000_FFFF_FFFF, the empty code, and the read index holds.
- R4: Each handshake (`cpl_valid` and `cpl_ready` high at a clock edge) advances the read index by one. Completions leave in the order they were written.
- R5: A handshake on the slot at index `cfg_depth`-1 returns the read index to 0 and inverts the expected phase. Slots still carrying the old phase are then not offered.
- R6: While `cpl_valid` is high and `cpl_ready` is low, the entry stays offered, `cpl_tag` stays unchanged and the index does not move.
- R7: A producer write stores `prod_tag` with bit 0 replaced by the producer phase. That phase starts at 1 and toggles when the write index wraps at `cfg_depth`.
- R8: `outstanding` rises by one on `cmd_submit`, falls by one on each handshake, and stays unchanged when both occur in the same cycle.
- R9: `cmd_full` is high exactly when `outstanding` is greater than or equal to `cfg_max_cmds`.
- R10: The ring depth is programmable from 1 to 2**IDX_W slots. Both indices wrap at the programmed value, not at the storage size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | IDX_W+1 | Programmed ring depth in slots |
| cfg_max_cmds | input | CNT_W | Outstanding-command limit |
| prod_valid | input | 1 | Producer writes one slot this cycle |
| prod_tag | input | 64 | Completion tag to write (bit 0 replaced by phase) |
| cmd_submit | input | 1 | One command issued this cycle |
| cpl_ready | input | 1 | Sink accepts the offered completion |
| cpl_valid | output | 1 | A fresh completion is offered |
| cpl_tag | output | 64 | Offered slot value, or the empty code |
| outstanding | output | CNT_W | Commands issued and not yet completed |
| cmd_full | output | 1 | Outstanding count has reached the limit |

## Verification
The bench drains a full pass and then holds `cpl_ready` high over slots that still carry the old phase. A design that failed to invert the expected phase at the wrap would hand those stale tags out again. Tags are written with bit 0 set opposite to the producer phase, so a producer that stored the raw tag would corrupt the phase marker and stall or misfire the consumer. A second run uses a depth of three to catch indices that wrap at the storage size, which would leave the consumer waiting on empty slots. Submits are issued in the same cycle as a handshake, and an entry is held under backpressure. A counter that let one event win, or a stream that advanced while stalled, would show up there.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int SLOT_W = 64;
    localparam logic [SLOT_W-1:0] EMPTY_TAG = 64'h0000_0000_FFFF_FFFF;
endpackage

// File: rtl/rr_ring_mem.sv
module rr_ring_mem #(
    parameter int IDX_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [rr_pkg::SLOT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [rr_pkg::SLOT_W-1:0] rd_data
);
    localparam int SLOTS = 1 << IDX_W;

    logic [rr_pkg::SLOT_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [rr_pkg::SLOT_W-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_d = wr_data;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/rr_producer.sv
module rr_producer #(
    parameter int IDX_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W:0]            cfg_depth,
    input  logic                      prod_valid,
    input  logic [rr_pkg::SLOT_W-1:0] prod_tag,
    output logic                      wr_en,
    output logic [IDX_W-1:0]          wr_idx,
    output logic [rr_pkg::SLOT_W-1:0] wr_data
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             phase;
    } prod_state_t;

    prod_state_t st_d, st_q;
    logic [IDX_W:0] nxt_idx;

    always_comb begin
        st_d    = st_q;
        nxt_idx = {1'b0, st_q.idx} + (IDX_W+1)'(1);
        if (prod_valid) begin
            if (nxt_idx >= cfg_depth) begin
                st_d.idx   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.idx = nxt_idx[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{idx: '0, phase: 1'b1};
        else        st_q <= st_d;
    end

    assign wr_en   = prod_valid;
    assign wr_idx  = st_q.idx;
    assign wr_data = {prod_tag[rr_pkg::SLOT_W-1:1], st_q.phase};
endmodule

// File: rtl/rr_consumer.sv
module rr_consumer #(
    parameter int IDX_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W:0]            cfg_depth,
    input  logic [rr_pkg::SLOT_W-1:0] rd_data,
    input  logic                      cpl_ready,
    output logic [IDX_W-1:0]          rd_idx,
    output logic                      exp_phase,
    output logic                      cpl_valid,
    output logic [rr_pkg::SLOT_W-1:0] cpl_tag,
    output logic                      take
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             phase;
    } cons_state_t;

    cons_state_t st_d, st_q;
    logic [IDX_W:0] nxt_idx;
    logic           fresh;

    always_comb begin
        st_d    = st_q;
        fresh   = (rd_data[0] == st_q.phase);
        take    = fresh && cpl_ready;
        nxt_idx = {1'b0, st_q.idx} + (IDX_W+1)'(1);
        if (take) begin
            if (nxt_idx >= cfg_depth) begin
                st_d.idx   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.idx = nxt_idx[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{idx: '0, phase: 1'b1};
        else        st_q <= st_d;
    end

    assign rd_idx    = st_q.idx;
    assign exp_phase = st_q.phase;
    assign cpl_valid = fresh;
    assign cpl_tag   = fresh ? rd_data : rr_pkg::EMPTY_TAG;
endmodule

// File: rtl/rr_credit_count.sv
module rr_credit_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({inc, dec})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign full  = (st_q.cnt >= limit);
endmodule

// File: rtl/reply_ring_drain.sv
module reply_ring_drain #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W:0]            cfg_depth,
    input  logic [CNT_W-1:0]          cfg_max_cmds,
    input  logic                      prod_valid,
    input  logic [rr_pkg::SLOT_W-1:0] prod_tag,
    input  logic                      cmd_submit,
    input  logic                      cpl_ready,
    output logic                      cpl_valid,
    output logic [rr_pkg::SLOT_W-1:0] cpl_tag,
    output logic [CNT_W-1:0]          outstanding,
    output logic                      cmd_full
);
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    logic [rr_pkg::SLOT_W-1:0] wr_data;
    logic [IDX_W-1:0]          rd_idx;
    logic [rr_pkg::SLOT_W-1:0] rd_data;
    logic                      exp_phase;
    logic                      take;

    rr_producer #(.IDX_W(IDX_W)) u_prod (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .prod_valid(prod_valid), .prod_tag(prod_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    rr_ring_mem #(.IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    rr_consumer #(.IDX_W(IDX_W)) u_cons (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .rd_data(rd_data), .cpl_ready(cpl_ready),
        .rd_idx(rd_idx), .exp_phase(exp_phase),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .take(take)
    );

    rr_credit_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc(cmd_submit), .dec(take), .limit(cfg_max_cmds),
        .count(outstanding), .full(cmd_full)
    );
endmodule

// File: rtl/rr_drain_checker.sv
module rr_drain_checker #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [IDX_W:0]            cfg_depth,
    input logic [CNT_W-1:0]          cfg_max_cmds,
    input logic                      cmd_submit,
    input logic                      cpl_ready,
    input logic                      cpl_valid,
    input logic [rr_pkg::SLOT_W-1:0] cpl_tag,
    input logic [CNT_W-1:0]          outstanding,
    input logic                      cmd_full,
    input logic [IDX_W-1:0]          rd_idx,
    input logic                      exp_phase
);
    logic hs;
    logic at_last;
    assign hs      = cpl_valid && cpl_ready;
    assign at_last = (({1'b0, rd_idx} + (IDX_W+1)'(1)) >= cfg_depth);

    a_r2_valid_phase: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_tag[0] == exp_phase));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpl_valid |=> $stable(rd_idx) && $stable(exp_phase));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !at_last) |=> (rd_idx == $past(rd_idx) + IDX_W'(1)) && $stable(exp_phase));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && at_last) |=> (rd_idx == '0) && (exp_phase != $past(exp_phase)));

    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> cpl_valid && $stable(cpl_tag) && $stable(rd_idx));

    a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> outstanding == CNT_W'($past(outstanding) + CNT_W'($past(cmd_submit))
                                         - CNT_W'($past(hs))));

    a_r9_full_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |-> (outstanding >= cfg_max_cmds));
endmodule

bind reply_ring_drain rr_drain_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_max_cmds(cfg_max_cmds),
    .cmd_submit(cmd_submit), .cpl_ready(cpl_ready), .cpl_valid(cpl_valid),
    .cpl_tag(cpl_tag), .outstanding(outstanding), .cmd_full(cmd_full),
    .rd_idx(rd_idx), .exp_phase(exp_phase)
);

// File: tb/test_reply_ring_drain.sv
module test_reply_ring_drain;
    localparam int IDX_W = 4;
    localparam int CNT_W = 8;
    localparam logic [63:0] EMPTY = 64'h0000_0000_FFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W:0]    cfg_depth = (IDX_W+1)'(4);
    logic [CNT_W-1:0]  cfg_max_cmds = CNT_W'(3);
    logic              prod_valid = 1'b0;
    logic [63:0]       prod_tag = '0;
    logic              cmd_submit = 1'b0;
    logic              cpl_ready = 1'b0;
    logic              cpl_valid;
    logic [63:0]       cpl_tag;
    logic [CNT_W-1:0]  outstanding;
    logic              cmd_full;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q[$];
    int          b_idx = 0;
    logic        b_phase = 1'b1;

    always #4 clk = ~clk;

    reply_ring_drain #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_reply_ring_drain (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_max_cmds(cfg_max_cmds),
        .prod_valid(prod_valid), .prod_tag(prod_tag), .cmd_submit(cmd_submit),
        .cpl_ready(cpl_ready), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .outstanding(outstanding), .cmd_full(cmd_full)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor, sampling at the falling edge
    logic        prev_stall = 1'b0;
    logic [63:0] prev_tag = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(cpl_valid && cpl_tag == prev_tag, "R6 stalled entry held", cpl_tag, prev_tag);
            end
            if (cpl_valid && cpl_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected completion (stale or extra)", cpl_tag, EMPTY);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(cpl_tag == e, "R2 R4 R7 completion value/order", cpl_tag, e);
                end
            end
            if (!cpl_valid) begin
                chk(cpl_tag == EMPTY, "R3 empty code", cpl_tag, EMPTY);
            end
            prev_stall = cpl_valid && !cpl_ready;
            prev_tag   = cpl_tag;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic do_reset(input int depth);
        @(posedge clk); #1;
        rst_n = 1'b0;
        cfg_depth = (IDX_W+1)'(depth);
        prod_valid = 1'b0; cmd_submit = 1'b0; cpl_ready = 1'b0;
        exp_q.delete();
        b_idx = 0; b_phase = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic push(input logic [63:0] tag);
        @(posedge clk); #1;
        prod_valid = 1'b1;
        prod_tag   = tag;
        exp_q.push_back({tag[63:1], b_phase});
        b_idx++;
        if (b_idx >= int'(cfg_depth)) begin
            b_idx = 0;
            b_phase = ~b_phase;
        end
        @(posedge clk); #1;
        prod_valid = 1'b0;
    endtask

    task automatic submit(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 cmd_submit = 1'b1;
        end
        @(posedge clk); #1 cmd_submit = 1'b0;
    endtask

    task automatic drain_wait(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        // Phase A: depth 4, limit 3
        do_reset(4);
        @(negedge clk);
        chk(!cpl_valid, "R1 no entry after reset", 64'(cpl_valid), 64'd0);
        chk(cpl_tag == EMPTY, "R1 empty code after reset", cpl_tag, EMPTY);
        chk(outstanding == 0, "R1 count zero", 64'(outstanding), 64'd0);
        chk(!cmd_full, "R9 not full at zero", 64'(cmd_full), 64'd0);

        submit(2);
        @(negedge clk);
        chk(outstanding == 2 && !cmd_full, "R9 below limit", 64'(outstanding), 64'd2);
        submit(1);
        @(negedge clk);
        chk(outstanding == 3, "R8 submit raises count", 64'(outstanding), 64'd3);
        chk(cmd_full, "R9 full at limit", 64'(cmd_full), 64'd1);

        // Tags with bit 0 opposite to producer phase (R7), held under backpressure (R6)
        push(64'hA5A5_0000_1111_2220);
        push(64'h5A5A_0000_3333_4440);
        repeat (4) @(negedge clk);
        chk(cpl_valid, "R6 entry offered while stalled", 64'(cpl_valid), 64'd1);
        chk(outstanding == 3, "R6 count holds while stalled", 64'(outstanding), 64'd3);
        @(posedge clk); #1 cpl_ready = 1'b1;
        drain_wait("R4 two entries drained");
        @(negedge clk);
        chk(outstanding == 1, "R8 completions lower count", 64'(outstanding), 64'd1);
        chk(!cmd_full, "R9 leaves full", 64'(cmd_full), 64'd0);

        // Submit in the same cycle as a handshake
        push(64'h0123_4567_89AB_CDEE);
        cmd_submit = 1'b1;
        @(posedge clk); #1 cmd_submit = 1'b0;
        @(negedge clk);
        chk(outstanding == 1, "R8 submit and completion together", 64'(outstanding), 64'd1);
        chk(exp_q.size() == 0, "R4 simultaneous entry consumed", 64'(exp_q.size()), 64'd0);

        // Last slot of the pass, then stale slots must not be offered
        push(64'hFEDC_BA98_7654_3210);
        drain_wait("R5 last slot of pass consumed");
        repeat (6) @(negedge clk);
        chk(!cpl_valid, "R5 stale slot ignored after wrap", 64'(cpl_valid), 64'd0);
        chk(outstanding == 0, "R8 count back to zero", 64'(outstanding), 64'd0);

        // Second pass, producer phase now 0
        submit(2);
        push(64'h1111_2222_3333_4445);
        push(64'h6666_7777_8888_9999);
        drain_wait("R5 R7 second pass entries");
        @(negedge clk);
        chk(outstanding == 0, "R8 second pass count", 64'(outstanding), 64'd0);

        // Phase B: depth 3
        do_reset(3);
        @(negedge clk);
        chk(!cpl_valid && outstanding == 0, "R1 reset restores idle", 64'(cpl_valid), 64'd0);
        cpl_ready = 1'b1;
        submit(7);
        for (int i = 0; i < 7; i++) begin
            if (i == 3) begin
                @(posedge clk); #1 cpl_ready = 1'b0;
            end
            if (i == 5) begin
                @(posedge clk); #1 cpl_ready = 1'b1;
            end
            push(64'hC0DE_0000_0000_0000 | 64'(i * 6 + 2));
        end
        drain_wait("R10 depth three wraps twice");
        @(negedge clk);
        chk(outstanding == 0, "R10 all completions counted", 64'(outstanding), 64'd0);
        repeat (4) @(negedge clk);
        chk(!cpl_valid, "R10 R5 no stale after short ring wrap", 64'(cpl_valid), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule